// File: doc/BRIEF.md
# Two-Bit Framed Host Message Link

This block carries typed 16-bit messages between a console core and a host over two narrow buses. Each bus is two bits wide and stays low when idle. On the transmit side, four internal sources can each raise a request: a context-switch word, an audio sample, a memory read address and a vertical-blank notice. The link grants one request at a time, acknowledges it, and serialises it. A frame is a start symbol, then the message type, then the payload in 2-bit slices from the low end. It also steps a context-state pointer that wraps after a fixed number of words.

On the receive side, any non-zero value on an idle input begins a frame and is taken as the message type. The payload then arrives in eight 2-bit slices. Each complete frame is presented for one cycle as a valid strobe with its type and payload. Frames of the register-write type update a small set of control registers: two credit counters and a control field. Their addresses sit in the payload's upper byte.

Top module: `host_link`

## Requirements
- R1: `tx_bus` is 2'b00 whenever no transmit frame is in flight, including the one cycle that follows the end of every frame.
- R2: A transmit frame is 2'b01 for one cycle, then the type for one cycle, then eight cycles carrying payload bits [1:0], [3:2] … [15:14] in that order.
- R3: Type codes on transmit are 0 for context switch, 1 for sample, 2 for read request and 3 for vertical blank; a vertical-blank frame carries an all-zero payload.
- R4: With several requests pending, grants go to context switch first, then sample, then read, then vertical blank. The matching acknowledge is high for exactly the cycle in which `tx_bus` shows 2'b01, and the payload is captured at that grant.
- R5: `ctx_ptr` resets to 0 and advances by one on every context-switch grant, becoming 0 again after the value CTX_WORDS-1 (35).
- R6: On receive, a non-zero `rx_bus` on an idle link is the frame type, and the next eight cycles carry payload bits lowest first. `rx_valid` is high for exactly one cycle right after the last slice, with `rx_type` and `rx_payload`. A new type value may follow that last slice directly.
- R7: A received type-3 frame writes payload[7:0] into the register named by payload[15:8]: address 0 is `credit_smp`, address 1 is `credit_aux`, and address 2 is `ctrl_reg`, which takes payload[4:0]. The new value is visible the cycle after `rx_valid`.
- R8: Type-3 frames with an address above 2, and frames of types 1 and 2, leave all three registers unchanged.
- R9: Synchronous reset sets `credit_smp` and `credit_aux` to 1 and `ctrl_reg` to 5'b01011, and clears all strobes, acknowledges and bus outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_bus | output | 2 | Outgoing serial lane |
| rx_bus | input | 2 | Incoming serial lane |
| ctx_req | input | 1 | Context-switch word waiting |
| ctx_word | input | 16 | Context-switch payload |
| ctx_ack | output | 1 | Context-switch request granted |
| smp_req | input | 1 | Audio sample waiting |
| smp_word | input | 16 | Signed sample payload |
| smp_ack | output | 1 | Sample request granted |
| rd_req | input | 1 | Read request waiting |
| rd_addr | input | 16 | Read address payload |
| rd_ack | output | 1 | Read request granted |
| vbl_req | input | 1 | Vertical-blank notice waiting |
| vbl_ack | output | 1 | Vertical-blank request granted |
| ctx_ptr | output | 6 | Context-state word index |
| rx_valid | output | 1 | Received frame complete strobe |
| rx_type | output | 2 | Type of the received frame |
| rx_payload | output | 16 | Payload of the received frame |
| credit_smp | output | 8 | Sample credit register |
| credit_aux | output | 8 | Auxiliary credit register |
| ctrl_reg | output | 5 | Control register |

## Verification
The embedded properties assume that each requester holds its request and payload steady until its acknowledge. They also assume that the host never drives a non-zero header while a receive frame is still collecting slices, because the receiver cannot tell a header from a payload slice. The bench drops each request on the cycle its acknowledge appears. It keeps payload inputs constant while a request is pending, and it drives `rx_bus` only in whole frames. All request masks are swept, as are register addresses 0 to 7 with several data values, and long runs of context-switch grants.

// File: rtl/host_link_pkg.sv
`timescale 1ns/1ps
package host_link_pkg;
  localparam int LANE_W = 2;
  localparam logic [LANE_W-1:0] START_SYM = 2'b01;

  typedef enum logic [1:0] {
    TX_CTX = 2'd0,
    TX_SMP = 2'd1,
    TX_RD  = 2'd2,
    TX_VBL = 2'd3
  } tx_kind_e;

  typedef enum logic [1:0] {
    RX_IDLE     = 2'd0,
    RX_CTX_RESP = 2'd1,
    RX_RD_RESP  = 2'd2,
    RX_REG_WR   = 2'd3
  } rx_kind_e;
endpackage

// File: rtl/host_link_tx.sv
`timescale 1ns/1ps
module host_link_tx
  import host_link_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int CTX_WORDS = 36,
  parameter int PTR_W     = $clog2(CTX_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           req,
  input  logic [PAYLOAD_W-1:0] ctx_data,
  input  logic [PAYLOAD_W-1:0] smp_data,
  input  logic [PAYLOAD_W-1:0] rd_data,
  output logic [LANE_W-1:0]    tx_bus,
  output logic [3:0]           ack,
  output logic [PTR_W-1:0]     ctx_ptr
);
  localparam int BEATS = PAYLOAD_W / LANE_W;
  localparam int CNT_W = $clog2(BEATS + 2);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS);
  localparam logic [PTR_W-1:0] PTR_TOP   = PTR_W'(CTX_WORDS - 1);

  logic                 busy;
  logic [CNT_W-1:0]     phase;
  tx_kind_e             kind_q;
  logic [PAYLOAD_W-1:0] shreg;

  logic [3:0]           grant_oh;
  tx_kind_e             grant_kind;
  logic [PAYLOAD_W-1:0] sel_payload;

  // lowest index wins: the last assignment in the descending loop
  always_comb begin
    grant_oh   = '0;
    grant_kind = TX_CTX;
    for (int i = 3; i >= 0; i--) begin
      if (req[i]) begin
        grant_oh    = '0;
        grant_oh[i] = 1'b1;
        grant_kind  = tx_kind_e'(i[1:0]);
      end
    end
  end

  always_comb begin
    case (grant_kind)
      TX_CTX:  sel_payload = ctx_data;
      TX_SMP:  sel_payload = smp_data;
      TX_RD:   sel_payload = rd_data;
      default: sel_payload = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      phase   <= '0;
      kind_q  <= TX_CTX;
      shreg   <= '0;
      tx_bus  <= '0;
      ack     <= '0;
      ctx_ptr <= '0;
    end else begin
      ack <= '0;
      if (!busy) begin
        if (|req) begin
          busy   <= 1'b1;
          phase  <= '0;
          tx_bus <= START_SYM;
          ack    <= grant_oh;
          kind_q <= grant_kind;
          shreg  <= sel_payload;
          if (grant_kind == TX_CTX)
            ctx_ptr <= (ctx_ptr == PTR_TOP) ? '0 : ctx_ptr + 1'b1;
        end else begin
          tx_bus <= '0;
        end
      end else if (phase == '0) begin
        tx_bus <= kind_q;
        phase  <= phase + 1'b1;
      end else if (phase <= LAST_BEAT) begin
        tx_bus <= shreg[LANE_W-1:0];
        shreg  <= shreg >> LANE_W;
        phase  <= phase + 1'b1;
      end else begin
        tx_bus <= '0;
        busy   <= 1'b0;
      end
    end
  end

  a_r2_start_symbol: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> tx_bus == START_SYM);
  a_r1_gap_after_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> tx_bus == '0);
  a_r4_ack_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));
  a_r4_ack_on_start: assert property (@(posedge clk) disable iff (rst)
    (|ack) |-> tx_bus == START_SYM);
  a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ctx_ptr} < (PTR_W+1)'(CTX_WORDS));
endmodule

// File: rtl/host_link_rx.sv
`timescale 1ns/1ps
module host_link_rx
  import host_link_pkg::*;
#(
  parameter int PAYLOAD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LANE_W-1:0]    rx_bus,
  output logic                 rx_valid,
  output logic [1:0]           rx_type,
  output logic [PAYLOAD_W-1:0] rx_payload
);
  localparam int BEATS = PAYLOAD_W / LANE_W;
  localparam int CNT_W = $clog2(BEATS);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic                 active;
  logic [CNT_W-1:0]     cnt;
  logic [1:0]           kind_q;
  logic [PAYLOAD_W-1:0] sh;
  logic [PAYLOAD_W-1:0] sh_next;

  assign sh_next = {rx_bus, sh[PAYLOAD_W-1:LANE_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      cnt        <= '0;
      kind_q     <= '0;
      sh         <= '0;
      rx_valid   <= 1'b0;
      rx_type    <= '0;
      rx_payload <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!active) begin
        if (rx_bus != '0) begin
          active <= 1'b1;
          cnt    <= '0;
          kind_q <= rx_bus;
        end
      end else begin
        sh  <= sh_next;
        cnt <= cnt + 1'b1;
        if (cnt == LAST_BEAT) begin
          active     <= 1'b0;
          rx_valid   <= 1'b1;
          rx_type    <= kind_q;
          rx_payload <= sh_next;
        end
      end
    end
  end

  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  a_r6_type_nonzero: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_type != RX_IDLE);
endmodule

// File: rtl/host_link_regs.sv
`timescale 1ns/1ps
module host_link_regs
  import host_link_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int CTRL_W    = 5,
  parameter logic [CTRL_W-1:0] CTRL_RESET = 5'b01011
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_valid,
  input  logic [1:0]             wr_type,
  input  logic [PAYLOAD_W-1:0]   wr_payload,
  output logic [PAYLOAD_W/2-1:0] credit_smp,
  output logic [PAYLOAD_W/2-1:0] credit_aux,
  output logic [CTRL_W-1:0]      ctrl_reg
);
  localparam int BYTE_W = PAYLOAD_W / 2;
  localparam logic [BYTE_W-1:0] ADDR_SMP  = BYTE_W'(0);
  localparam logic [BYTE_W-1:0] ADDR_AUX  = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] ADDR_CTRL = BYTE_W'(2);

  logic [BYTE_W-1:0] addr;
  logic [BYTE_W-1:0] data;
  logic              wr_en;

  assign addr  = wr_payload[PAYLOAD_W-1:BYTE_W];
  assign data  = wr_payload[BYTE_W-1:0];
  assign wr_en = wr_valid && (wr_type == RX_REG_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_smp <= BYTE_W'(1);
      credit_aux <= BYTE_W'(1);
      ctrl_reg   <= CTRL_RESET;
    end else if (wr_en) begin
      case (addr)
        ADDR_SMP:  credit_smp <= data;
        ADDR_AUX:  credit_aux <= data;
        ADDR_CTRL: ctrl_reg   <= data[CTRL_W-1:0];
        default:   ;
      endcase
    end
  end

  a_r8_undef_addr_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_type == RX_REG_WR && addr > ADDR_CTRL) |=>
      ($stable(credit_smp) && $stable(credit_aux) && $stable(ctrl_reg)));
  a_r8_other_types_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_type != RX_REG_WR) |=>
      ($stable(credit_smp) && $stable(credit_aux) && $stable(ctrl_reg)));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> ($stable(credit_smp) && $stable(credit_aux) && $stable(ctrl_reg)));
endmodule

// File: rtl/host_link.sv
`timescale 1ns/1ps
module host_link
  import host_link_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int CTX_WORDS = 36,
  parameter int CTRL_W    = 5,
  parameter int PTR_W     = $clog2(CTX_WORDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [1:0]             tx_bus,
  input  logic [1:0]             rx_bus,
  input  logic                   ctx_req,
  input  logic [PAYLOAD_W-1:0]   ctx_word,
  output logic                   ctx_ack,
  input  logic                   smp_req,
  input  logic [PAYLOAD_W-1:0]   smp_word,
  output logic                   smp_ack,
  input  logic                   rd_req,
  input  logic [PAYLOAD_W-1:0]   rd_addr,
  output logic                   rd_ack,
  input  logic                   vbl_req,
  output logic                   vbl_ack,
  output logic [PTR_W-1:0]       ctx_ptr,
  output logic                   rx_valid,
  output logic [1:0]             rx_type,
  output logic [PAYLOAD_W-1:0]   rx_payload,
  output logic [PAYLOAD_W/2-1:0] credit_smp,
  output logic [PAYLOAD_W/2-1:0] credit_aux,
  output logic [CTRL_W-1:0]      ctrl_reg
);
  logic [3:0] req_vec;
  logic [3:0] ack_vec;

  assign req_vec = {vbl_req, rd_req, smp_req, ctx_req};
  assign {vbl_ack, rd_ack, smp_ack, ctx_ack} = ack_vec;

  host_link_tx #(.PAYLOAD_W(PAYLOAD_W), .CTX_WORDS(CTX_WORDS), .PTR_W(PTR_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .req      (req_vec),
    .ctx_data (ctx_word),
    .smp_data (smp_word),
    .rd_data  (rd_addr),
    .tx_bus   (tx_bus),
    .ack      (ack_vec),
    .ctx_ptr  (ctx_ptr)
  );

  host_link_rx #(.PAYLOAD_W(PAYLOAD_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_bus     (rx_bus),
    .rx_valid   (rx_valid),
    .rx_type    (rx_type),
    .rx_payload (rx_payload)
  );

  host_link_regs #(.PAYLOAD_W(PAYLOAD_W), .CTRL_W(CTRL_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (rx_valid),
    .wr_type    (rx_type),
    .wr_payload (rx_payload),
    .credit_smp (credit_smp),
    .credit_aux (credit_aux),
    .ctrl_reg   (ctrl_reg)
  );
endmodule

// File: tb/host_link_tb.sv
`timescale 1ns/1ps
module host_link_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  tx_bus;
  logic [1:0]  rx_bus = '0;
  logic        ctx_req = 0, smp_req = 0, rd_req = 0, vbl_req = 0;
  logic [15:0] ctx_word = '0, smp_word = '0, rd_addr = '0;
  logic        ctx_ack, smp_ack, rd_ack, vbl_ack;
  logic [5:0]  ctx_ptr;
  logic        rx_valid;
  logic [1:0]  rx_type;
  logic [15:0] rx_payload;
  logic [7:0]  credit_smp, credit_aux;
  logic [4:0]  ctrl_reg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int model_ptr = 0;
  logic [7:0] m_smp = 8'd1, m_aux = 8'd1;
  logic [4:0] m_ctrl = 5'b01011;

  always #2 clk = ~clk;

  host_link u_dut (
    .clk(clk), .rst(rst), .tx_bus(tx_bus), .rx_bus(rx_bus),
    .ctx_req(ctx_req), .ctx_word(ctx_word), .ctx_ack(ctx_ack),
    .smp_req(smp_req), .smp_word(smp_word), .smp_ack(smp_ack),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .vbl_req(vbl_req), .vbl_ack(vbl_ack), .ctx_ptr(ctx_ptr),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_payload(rx_payload),
    .credit_smp(credit_smp), .credit_aux(credit_aux), .ctrl_reg(ctrl_reg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pay(input int n);
    return 16'(n * 40503 + 12345);
  endfunction

  task automatic check_regs(input string req);
    chk(req, {24'd0, credit_smp}, {24'd0, m_smp});
    chk(req, {24'd0, credit_aux}, {24'd0, m_aux});
    chk(req, {27'd0, ctrl_reg}, {27'd0, m_ctrl});
  endtask

  // called at a negedge with the link idle
  task automatic serve(input logic [3:0] mask, input int seq);
    logic [3:0] pending;
    logic [15:0] exp_pl;
    int k;
    pending  = mask;
    ctx_word = pay(seq);
    smp_word = pay(seq + 1);
    rd_addr  = pay(seq + 2);
    {vbl_req, rd_req, smp_req, ctx_req} = mask;
    while (pending != 0) begin
      @(posedge clk); @(negedge clk);
      k = 0;
      for (int i = 3; i >= 0; i--) if (pending[i]) k = i;
      chk("R4 grant order", {28'd0, vbl_ack, rd_ack, smp_ack, ctx_ack}, 32'(1 << k));
      chk("R2 start symbol", {30'd0, tx_bus}, 32'd1);
      if (k == 0) begin
        model_ptr = (model_ptr == 35) ? 0 : model_ptr + 1;
        chk("R5 context pointer", {26'd0, ctx_ptr}, 32'(model_ptr));
      end
      case (k)
        0: begin exp_pl = ctx_word; ctx_req = 0; end
        1: begin exp_pl = smp_word; smp_req = 0; end
        2: begin exp_pl = rd_addr;  rd_req  = 0; end
        default: begin exp_pl = 16'h0000; vbl_req = 0; end
      endcase
      pending[k] = 1'b0;
      @(negedge clk);
      chk("R3 type code", {30'd0, tx_bus}, 32'(k));
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        chk("R2 payload slice", {30'd0, tx_bus}, {30'd0, exp_pl[2*b +: 2]});
      end
      @(negedge clk);
      chk("R1 idle gap", {30'd0, tx_bus}, 32'd0);
      chk("R4 ack cleared", {28'd0, vbl_ack, rd_ack, smp_ack, ctx_ack}, 32'd0);
    end
  endtask

  // called at a negedge with the receiver idle; returns at the negedge where rx_valid shows
  task automatic rx_send(input logic [1:0] typ, input logic [15:0] pl, input bit idle_after);
    rx_bus = typ;
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      rx_bus = pl[2*b +: 2];
    end
    @(negedge clk);
    chk("R6 valid strobe", {31'd0, rx_valid}, 32'd1);
    chk("R6 received type", {30'd0, rx_type}, {30'd0, typ});
    chk("R6 received payload", {16'd0, rx_payload}, {16'd0, pl});
    if (idle_after) rx_bus = '0;
    if (typ == 2'd3) begin
      case (pl[15:8])
        8'd0: m_smp = pl[7:0];
        8'd1: m_aux = pl[7:0];
        8'd2: m_ctrl = pl[4:0];
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 / R7: reset values
    chk("R9 tx idle at reset", {30'd0, tx_bus}, 32'd0);
    chk("R9 acks at reset", {28'd0, vbl_ack, rd_ack, smp_ack, ctx_ack}, 32'd0);
    chk("R9 rx_valid at reset", {31'd0, rx_valid}, 32'd0);
    chk("R5 pointer at reset", {26'd0, ctx_ptr}, 32'd0);
    check_regs("R7 reset values");
    repeat (3) @(negedge clk);
    chk("R1 idle with no request", {30'd0, tx_bus}, 32'd0);

    for (int m = 1; m < 16; m++) serve(4'(m), m * 7);
    for (int n = 0; n < 40; n++) serve(4'b0001, 200 + n);
    serve(4'b1000, 999);

    // register writes: sweep addresses and data values
    for (int a = 0; a < 8; a++) begin
      for (int v = 0; v < 4; v++) begin
        logic [7:0] d;
        d = (v == 0) ? 8'h00 : (v == 1) ? 8'hFF : (v == 2) ? 8'h5A : 8'(a * 37 + 3);
        rx_send(2'd3, {8'(a), d}, 1'b1);
        @(negedge clk);
        chk("R6 strobe single", {31'd0, rx_valid}, 32'd0);
        if (a > 2) check_regs("R8 undefined address");
        else check_regs("R7 register write");
      end
    end

    // responses must not touch the registers
    rx_send(2'd1, 16'h00A7, 1'b1);
    @(negedge clk);
    check_regs("R8 type 1 ignored");
    rx_send(2'd2, 16'h0133, 1'b1);
    @(negedge clk);
    check_regs("R8 type 2 ignored");

    // back-to-back receive frames
    rx_send(2'd1, 16'hBEEF, 1'b0);
    rx_send(2'd3, 16'h0214, 1'b1);
    @(negedge clk);
    chk("R6 back-to-back single strobe", {31'd0, rx_valid}, 32'd0);
    check_regs("R7 write after back-to-back");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule